// File: doc/BRIEF.md
# Wireless Device Bring-Up Sequencer

This block is the host-side controller that takes a serially attached wireless device from power-up to a usable state. Once reset is released it waits out a settle interval. It then reads a fixed identification word from the device until a known signature comes back. Next it issues a wake-up write and, on a cold start, waits until the device reports that its low-power clock is running. On a cold start it also writes the crystal frequency into a power-management register, which starts the device's PLL. The sequence finishes when the device raises its ready interrupt.

The sequencer does not handle serial bit timing. It presents one abstract read or write request at a time (valid/ready, function number, address, write data) to a separate serial master, and it takes read responses back as a one-cycle valid strobe with data. A restart input sends the sequence back to the settle phase. If warm-boot is set together with restart, the clock wait and the crystal write are skipped. Exhausted poll retries and wait timeouts end in a sticky error state.

States: `BUP_SETTLE` leaves when the settle timer expires and goes to `BUP_POLL_REQ`. `BUP_POLL_REQ` goes to `BUP_POLL_WAIT` once the read is accepted. `BUP_POLL_WAIT` goes to `BUP_WAKE_REQ` on a signature match. On a mismatch it goes to `BUP_POLL_GAP`, or to `BUP_ERROR` if that was the last allowed try. `BUP_POLL_GAP` returns to `BUP_POLL_REQ` when its timer expires. `BUP_WAKE_REQ` goes to `BUP_CLK_WAIT` on a cold start and to `BUP_IRQ_WAIT` on a warm restart. `BUP_CLK_WAIT` goes to `BUP_XTAL_REQ` when the clock is available and to `BUP_ERROR` on timeout. `BUP_XTAL_REQ` goes to `BUP_IRQ_WAIT` once the write is accepted. `BUP_IRQ_WAIT` goes to `BUP_READY` on the interrupt and to `BUP_ERROR` on timeout. `BUP_READY` and `BUP_ERROR` hold their state. A restart that is applied moves any state to `BUP_SETTLE`.

Top module: `wlan_bringup_seq`

## Requirements
- R1: While reset is active and right after it, ready_o, error_o and req_valid_o are all low.
- R2: The first identification read appears exactly SETTLE_CYC+1 clock edges after reset release, and likewise after an applied restart. No request is presented before then.
- R3: Each identification read has req_write_o=0, req_func_o=0 and req_addr_o=ID_ADDR (0x14).
- R4: If a read response differs from SIG, the next identification read appears POLL_GAP_CYC+1 edges after the response edge. A response equal to SIG moves the sequence on to the wake-up write.
- R5: If POLL_MAX responses in a row mismatch, error_o goes high in the cycle after the last response. No earlier mismatch raises it.
- R6: The wake-up request is a write with req_func_o=0, req_addr_o=0 and req_wdata_o=0x80, meaning bit 7 set and all other bits clear.
- R7: On a cold start, no request is presented after the wake-up write is accepted until lpclk_avail_i is high. The next request is then a write with req_func_o=XTAL_FUNC, req_addr_o=XTAL_ADDR and req_wdata_o=XTAL_VAL.
- R8: When dev_irq_i (active high) is seen high while waiting for ready, ready_o goes high in the next cycle. It stays high with no request presented until a restart.
- R9: If the clock wait lasts CLK_TMO_CYC+1 edges, error_o is raised. If the ready-interrupt wait lasts IRQ_TMO_CYC+1 edges, error_o is raised. Both counts start at the acceptance edge of the preceding write.
- R10: error_o holds whatever lpclk_avail_i and dev_irq_i do, until a restart. ready_o and error_o are never high together.
- R11: A restart with warm_boot_i=1 goes straight from the wake-up write to the ready-interrupt wait and issues no crystal write. A restart with warm_boot_i=0 performs the clock wait and the crystal write.
- R12: A presented request keeps req_valid_o high and all of its fields stable until req_ready_i is seen. At most one request is open at a time.
- R13: A restart is applied at the next edge unless a request is being presented. In that case it waits until the request is accepted. A read response that arrives once the restart has been applied is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Pulse that sends the sequence back to settle |
| warm_boot_i | input | 1 | Sampled with restart_i; 1 skips clock wait and crystal write |
| req_valid_o | output | 1 | Request presented to the serial master |
| req_ready_i | input | 1 | Serial master accepts the request this cycle |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_func_o | output | 2 | Function number of the access |
| req_addr_o | output | ADDR_W | Register address |
| req_wdata_o | output | DATA_W | Write data |
| rsp_valid_i | input | 1 | One-cycle read response strobe |
| rsp_data_i | input | DATA_W | Read response data |
| lpclk_avail_i | input | 1 | Device low-power clock is available |
| dev_irq_i | input | 1 | Device-ready interrupt, active high |
| ready_o | output | 1 | Bring-up complete |
| error_o | output | 1 | Sticky bring-up failure |

## Verification
Each result has a fixed due cycle, counted from the clock edge at which its cause is registered. The first poll is due SETTLE_CYC+1 edges after reset release or restart. Repeat polls are due POLL_GAP_CYC+1 edges after a bad response, and timeouts are due CLK_TMO_CYC+1 or IRQ_TMO_CYC+1 edges after the accepting edge. The ready or error flag is due one edge after the deciding input. The bench drives inputs at the falling edge and samples outputs there. It counts rising edges from the causing edge up to the first falling edge at which the output has changed, and compares that count with the arithmetic value. A sweep over the number of bad polls, from none up to the retry limit, checks both the match path and the exhaustion path.

// File: rtl/bup_pkg.sv
package bup_pkg;

    typedef enum logic [3:0] {
        BUP_SETTLE,
        BUP_POLL_REQ,
        BUP_POLL_WAIT,
        BUP_POLL_GAP,
        BUP_WAKE_REQ,
        BUP_CLK_WAIT,
        BUP_XTAL_REQ,
        BUP_IRQ_WAIT,
        BUP_READY,
        BUP_ERROR
    } bup_state_e;

    function automatic int unsigned bup_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bup_timer.sv
module bup_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/bup_poll_ctr.sv
module bup_poll_ctr #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CW'(MAX - 1))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == CW'(MAX - 1));
endmodule

// File: rtl/bup_restart_ctl.sv
module bup_restart_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic warm_i,
    input  logic busy_i,
    output logic apply_o,
    output logic warm_o
);
    logic pend_q;
    logic warm_q;

    assign apply_o = (restart_i || pend_q) && !busy_i;
    assign warm_o  = restart_i ? warm_i : warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            warm_q <= 1'b0;
        end else begin
            if (restart_i) begin
                warm_q <= warm_i;
            end
            if (apply_o) begin
                pend_q <= 1'b0;
            end else if (restart_i) begin
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wlan_bringup_seq.sv
module wlan_bringup_seq
    import bup_pkg::*;
#(
    parameter int                ADDR_W       = 17,
    parameter int                DATA_W       = 32,
    parameter int unsigned       SETTLE_CYC   = 5_000_000,
    parameter int unsigned       POLL_GAP_CYC = 1000,
    parameter int                POLL_MAX     = 64,
    parameter int unsigned       CLK_TMO_CYC  = 1_000_000,
    parameter int unsigned       IRQ_TMO_CYC  = 1_000_000,
    parameter logic [ADDR_W-1:0] ID_ADDR      = 'h14,
    parameter logic [DATA_W-1:0] SIG          = 'hFEED_BEAD,
    parameter logic [ADDR_W-1:0] WAKE_ADDR    = 'h0,
    parameter int                WAKE_BIT     = 7,
    parameter logic [1:0]        XTAL_FUNC    = 2'd1,
    parameter logic [ADDR_W-1:0] XTAL_ADDR    = 'h0660,
    parameter logic [DATA_W-1:0] XTAL_VAL     = 'd37400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              warm_boot_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic              req_write_o,
    output logic [1:0]        req_func_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              lpclk_avail_i,
    input  logic              dev_irq_i,
    output logic              ready_o,
    output logic              error_o
);
    localparam int unsigned TMR_MAX = bup_max(bup_max(SETTLE_CYC, POLL_GAP_CYC),
                                              bup_max(CLK_TMO_CYC, IRQ_TMO_CYC));
    localparam int TMR_W = $clog2(TMR_MAX + 1);
    localparam logic [DATA_W-1:0] WAKE_DATA = DATA_W'(1) << WAKE_BIT;

    bup_state_e       state_q, state_d;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             poll_clr;
    logic             poll_inc;
    logic             poll_last;
    logic             rs_apply;
    logic             rs_warm;
    logic             skip_xtal_q;

    bup_timer #(
        .W       (TMR_W),
        .RST_VAL (int'(SETTLE_CYC))
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_expired)
    );

    bup_poll_ctr #(
        .MAX (POLL_MAX)
    ) i_poll_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (poll_clr),
        .inc_i  (poll_inc),
        .last_o (poll_last)
    );

    bup_restart_ctl i_restart (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .warm_i    (warm_boot_i),
        .busy_i    (req_valid_o),
        .apply_o   (rs_apply),
        .warm_o    (rs_warm)
    );

    // next-state, timer and poll-counter control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        if (rs_apply) begin
            state_d  = BUP_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(SETTLE_CYC);
            poll_clr = 1'b1;
        end else begin
            unique case (state_q)
                BUP_SETTLE: begin
                    if (tmr_expired) state_d = BUP_POLL_REQ;
                end
                BUP_POLL_REQ: begin
                    if (req_ready_i) state_d = BUP_POLL_WAIT;
                end
                BUP_POLL_WAIT: begin
                    if (rsp_valid_i) begin
                        if (rsp_data_i == SIG) begin
                            state_d = BUP_WAKE_REQ;
                        end else if (poll_last) begin
                            state_d = BUP_ERROR;
                        end else begin
                            state_d  = BUP_POLL_GAP;
                            poll_inc = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = TMR_W'(POLL_GAP_CYC);
                        end
                    end
                end
                BUP_POLL_GAP: begin
                    if (tmr_expired) state_d = BUP_POLL_REQ;
                end
                BUP_WAKE_REQ: begin
                    if (req_ready_i) begin
                        tmr_load = 1'b1;
                        if (skip_xtal_q) begin
                            state_d = BUP_IRQ_WAIT;
                            tmr_val = TMR_W'(IRQ_TMO_CYC);
                        end else begin
                            state_d = BUP_CLK_WAIT;
                            tmr_val = TMR_W'(CLK_TMO_CYC);
                        end
                    end
                end
                BUP_CLK_WAIT: begin
                    if (lpclk_avail_i)    state_d = BUP_XTAL_REQ;
                    else if (tmr_expired) state_d = BUP_ERROR;
                end
                BUP_XTAL_REQ: begin
                    if (req_ready_i) begin
                        state_d  = BUP_IRQ_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(IRQ_TMO_CYC);
                    end
                end
                BUP_IRQ_WAIT: begin
                    if (dev_irq_i)        state_d = BUP_READY;
                    else if (tmr_expired) state_d = BUP_ERROR;
                end
                BUP_READY: state_d = BUP_READY;
                BUP_ERROR: state_d = BUP_ERROR;
                default:   state_d = BUP_ERROR;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= BUP_SETTLE;
            skip_xtal_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rs_apply) skip_xtal_q <= rs_warm;
        end
    end

    // outputs
    always_comb begin
        req_valid_o = 1'b0;
        req_write_o = 1'b0;
        req_func_o  = 2'd0;
        req_addr_o  = '0;
        req_wdata_o = '0;
        ready_o     = 1'b0;
        error_o     = 1'b0;
        unique case (state_q)
            BUP_POLL_REQ: begin
                req_valid_o = 1'b1;
                req_addr_o  = ID_ADDR;
            end
            BUP_WAKE_REQ: begin
                req_valid_o = 1'b1;
                req_write_o = 1'b1;
                req_addr_o  = WAKE_ADDR;
                req_wdata_o = WAKE_DATA;
            end
            BUP_XTAL_REQ: begin
                req_valid_o = 1'b1;
                req_write_o = 1'b1;
                req_func_o  = XTAL_FUNC;
                req_addr_o  = XTAL_ADDR;
                req_wdata_o = XTAL_VAL;
            end
            BUP_READY: ready_o = 1'b1;
            BUP_ERROR: error_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bup_checks.sv
module bup_checks #(
    parameter int                ADDR_W  = 17,
    parameter int                DATA_W  = 32,
    parameter logic [ADDR_W-1:0] ID_ADDR = 'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart_i,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic              req_write_o,
    input logic [1:0]        req_func_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [DATA_W-1:0] req_wdata_o,
    input logic              dev_irq_i,
    input logic              ready_o,
    input logic              error_o
);
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
        $stable(req_wdata_o) && $stable(req_write_o) && $stable(req_func_o));

    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error_o && !restart_i |=> error_o);

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && error_o));

    a_r8_ready_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(dev_irq_i));

    a_r8_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !req_valid_o);

    a_r3_read_target: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_write_o |-> req_addr_o == ID_ADDR && req_func_o == 2'd0);
endmodule

bind wlan_bringup_seq bup_checks #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ID_ADDR (ID_ADDR)
) i_bup_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (restart_i),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_write_o (req_write_o),
    .req_func_o  (req_func_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .dev_irq_i   (dev_irq_i),
    .ready_o     (ready_o),
    .error_o     (error_o)
);

// File: tb/test_wlan_bringup_seq.sv
`timescale 1ns/1ps
module test_wlan_bringup_seq;
    localparam int          AW   = 17;
    localparam int          DW   = 32;
    localparam int          S    = 20;
    localparam int          G    = 3;
    localparam int          PM   = 4;
    localparam int          T    = 15;
    localparam int          I    = 12;
    localparam logic [31:0] SIGV = 32'hFEED_BEAD;
    localparam logic [31:0] BAD  = 32'h1234_5678;
    localparam logic [1:0]  XF   = 2'd1;
    localparam logic [16:0] XA   = 17'h0660;
    localparam logic [31:0] XV   = 32'd37400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart_i = 1'b0, warm_boot_i = 1'b0;
    logic req_valid_o, req_ready_i = 1'b0, req_write_o;
    logic [1:0] req_func_o;
    logic [AW-1:0] req_addr_o;
    logic [DW-1:0] req_wdata_o;
    logic rsp_valid_i = 1'b0;
    logic [DW-1:0] rsp_data_i = '0;
    logic lpclk_avail_i = 1'b0, dev_irq_i = 1'b0;
    logic ready_o, error_o;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wlan_bringup_seq #(
        .ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(S), .POLL_GAP_CYC(G), .POLL_MAX(PM),
        .CLK_TMO_CYC(T), .IRQ_TMO_CYC(I), .SIG(SIGV), .XTAL_FUNC(XF),
        .XTAL_ADDR(XA), .XTAL_VAL(XV)
    ) i_wlan_bringup_seq (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .warm_boot_i(warm_boot_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_write_o(req_write_o),
        .req_func_o(req_func_o), .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .lpclk_avail_i(lpclk_avail_i),
        .dev_irq_i(dev_irq_i), .ready_o(ready_o), .error_o(error_o)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic count_valid(output int n);
        n = 0;
        while (!req_valid_o && n < 1000) begin tick(); n++; end
    endtask

    task automatic count_error(output int n);
        n = 0;
        while (!error_o && n < 1000) begin tick(); n++; end
    endtask

    // waits for a request, holds it off for 'hold' cycles, then accepts it
    task automatic take_req(input int hold, output logic w, output logic [1:0] f,
                            output logic [AW-1:0] a, output logic [DW-1:0] d);
        while (!req_valid_o) tick();
        w = req_write_o; f = req_func_o; a = req_addr_o; d = req_wdata_o;
        for (int i = 0; i < hold; i++) begin
            tick();
            chk(req_valid_o && req_addr_o == a && req_wdata_o == d && req_write_o == w
                && req_func_o == f, "R12 held request", 32'(req_addr_o), 32'(a));
        end
        req_ready_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready_i = 1'b0;
    endtask

    task automatic respond(input logic [31:0] data, input int lat);
        for (int i = 0; i < lat; i++) tick();
        rsp_valid_i = 1'b1;
        rsp_data_i  = data;
        @(posedge clk);
        @(negedge clk);
        rsp_valid_i = 1'b0;
    endtask

    task automatic do_poll(input logic [31:0] data, input int lat, input int hold);
        logic w; logic [1:0] f; logic [AW-1:0] a; logic [DW-1:0] d;
        take_req(hold, w, f, a, d);
        chk(w == 1'b0 && f == 2'd0 && a == 17'h14, "R3 poll read", 32'(a), 32'h14);
        respond(data, lat);
    endtask

    task automatic do_wake();
        logic w; logic [1:0] f; logic [AW-1:0] a; logic [DW-1:0] d;
        take_req(0, w, f, a, d);
        chk(w && f == 2'd0 && a == '0 && d == 32'h80, "R6 wake write", d, 32'h80);
    endtask

    task automatic do_xtal(input string rq);
        logic w; logic [1:0] f; logic [AW-1:0] a; logic [DW-1:0] d;
        take_req(0, w, f, a, d);
        chk(w && f == XF && a == XA && d == XV, rq, 32'(a), 32'(XA));
    endtask

    task automatic do_restart(input bit warm);
        int n;
        restart_i = 1'b1; warm_boot_i = warm;
        @(posedge clk);
        @(negedge clk);
        restart_i = 1'b0; warm_boot_i = 1'b0;
        chk(!ready_o && !error_o && !req_valid_o, "R13 restart applied next edge",
            {29'b0, ready_o, error_o, req_valid_o}, 32'h0);
        count_valid(n);
        chk(n == S + 1, "R2 settle after restart", n, S + 1);
    endtask

    initial begin
        int n;
        logic w; logic [1:0] f; logic [AW-1:0] a; logic [DW-1:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ready_o && !error_o && !req_valid_o, "R1 reset state",
            {29'b0, ready_o, error_o, req_valid_o}, 32'h0);
        rst_n = 1'b1;
        count_valid(n);
        chk(n == S + 1, "R2 settle after reset", n, S + 1);

        // two bad polls with different response latencies, then a match
        for (int i = 0; i < 2; i++) begin
            do_poll(BAD, i, i);
            count_valid(n);
            chk(n == G + 1, "R4 poll gap", n, G + 1);
        end
        do_poll(SIGV, 2, 0);
        take_req(3, w, f, a, d);
        chk(w && f == 2'd0 && a == '0 && d == 32'h80, "R6 wake write", d, 32'h80);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(!req_valid_o, "R7 no request before clock", req_valid_o, 0);
        end
        lpclk_avail_i = 1'b1;
        do_xtal("R7 crystal write");
        lpclk_avail_i = 1'b0;
        chk(!ready_o, "R8 not ready before irq", ready_o, 0);
        dev_irq_i = 1'b1;
        tick();
        chk(ready_o, "R8 ready one cycle after irq", ready_o, 1);
        dev_irq_i = 1'b0;
        repeat (5) tick();
        chk(ready_o && !req_valid_o, "R8 ready holds quietly", ready_o, 1);

        // warm restart: no clock wait, no crystal write
        do_restart(1'b1);
        do_poll(SIGV, 0, 0);
        do_wake();
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!req_valid_o && !ready_o, "R11 warm skips crystal", req_valid_o, 0);
        end
        dev_irq_i = 1'b1;
        tick();
        chk(ready_o, "R11 warm reaches ready", ready_o, 1);
        dev_irq_i = 1'b0;

        // cold restart, clock never available
        do_restart(1'b0);
        do_poll(SIGV, 1, 0);
        do_wake();
        count_error(n);
        chk(n == T + 1, "R9 clock wait timeout", n, T + 1);
        for (int i = 0; i < 8; i++) begin
            lpclk_avail_i = i[0]; dev_irq_i = i[1];
            tick();
            chk(error_o && !ready_o, "R10 error sticky", error_o, 1);
        end
        lpclk_avail_i = 1'b0; dev_irq_i = 1'b0;

        // warm restart, interrupt never comes
        do_restart(1'b1);
        do_poll(SIGV, 0, 1);
        do_wake();
        count_error(n);
        chk(n == I + 1, "R9 irq wait timeout", n, I + 1);

        // sweep the number of bad polls over the full retry range
        for (int k = 0; k <= PM; k++) begin
            do_restart(1'b0);
            for (int j = 0; j < k; j++) begin
                do_poll(BAD, j % 3, j % 2);
                if (j < PM - 1) begin
                    chk(!error_o, "R5 no early error", error_o, 0);
                    count_valid(n);
                    chk(n == G + 1, "R4 poll gap sweep", n, G + 1);
                end else begin
                    chk(error_o, "R5 retries exhausted", error_o, 1);
                end
            end
            if (k < PM) begin
                do_poll(SIGV, k % 2, 0);
                lpclk_avail_i = 1'b1;
                do_wake();
                do_xtal("R11 cold restart crystal write");
                lpclk_avail_i = 1'b0;
                dev_irq_i = 1'b1;
                tick();
                chk(ready_o, "R8 sweep ready", ready_o, 1);
                dev_irq_i = 1'b0;
            end
        end

        // restart during a held request is deferred; late response ignored
        do_restart(1'b0);
        restart_i = 1'b1; warm_boot_i = 1'b0;
        tick();
        restart_i = 1'b0;
        chk(req_valid_o && req_addr_o == 17'h14, "R13 request kept under restart",
            req_valid_o, 1);
        req_ready_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready_i = 1'b0;
        respond(SIGV, 0);
        count_valid(n);
        chk(n == S + 1, "R13 deferred restart settles", n, S + 1);
        chk(!req_write_o && req_addr_o == 17'h14, "R13 stale response ignored",
            32'(req_addr_o), 32'h14);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule